// File: doc/BRIEF.md
# In-Order Five-Stage Pipeline with a Single Shared Memory Port

The block is a small in-order processor pipeline: fetch, decode, execute, memory access and write-back, with an edge-triggered register between each pair of stages. Instruction fetch and data access go through one memory port. When a load or store sits in the memory stage it takes the port, and fetch loses that cycle. The fetched instruction waits in the fetch/decode register, and an empty slot goes into the decode/execute register in its place.

The memory sits outside the block and answers a read in the same cycle as the address. A write is taken at the clock edge when the write enable is high. The block has no forwarding. Code running on it must place a consumer at least three instructions after its producer. A register written in write-back can be read by decode in the same cycle. Two free-running counters, elapsed cycles and retired instructions, give the cycles per instruction. For a run with M memory instructions, the retired count after the pipeline has drained settles at cycles − 4 − M.

Top module: `sp_pipe_top`

## Requirements
- R1: While reset is held and in the first cycle after release: `stage_vld` is 0, `mem_wen` is 0, `fetch_stall` is 0, both counters are 0, and `mem_addr` equals BOOT_ADDR.
- R2: Encoding, 16-bit instruction: op in [15:12], rd in [11:9], rs1 in [8:6], rs2 in [5:3], imm in [5:0] zero-extended. The ops are 1 = ADD (rd = rs1 + rs2), 2 = ADDI (rd = rs1 + imm), 3 = LOAD (rd = mem[rs1 + imm]) and 4 = STORE (mem[rs1 + imm] = reg[rd]). Every other op does nothing. Register 0 reads as zero, and a write to it is dropped without a `wb_en` pulse.
- R3: `wb_en`/`wb_rd`/`wb_data` report every register write in program order. The values match sequential execution whenever each consumer is at least three instructions after its producer.
- R4: A valid load or store in the memory stage raises `fetch_stall` and drives its data address on `mem_addr`. A store also raises `mem_wen`. In every other cycle, `mem_addr` carries the fetch address and `mem_wen` is 0.
- R5: In a stall cycle the program counter and the fetch/decode register hold, and no fetch takes place. The fetch address therefore equals BOOT_ADDR plus the number of non-stall cycles since reset.
- R6: In the cycle after a stall, the decode/execute valid bit (`stage_vld[1]`) is 0.
- R7: Each load or store causes exactly one stall cycle. This includes back-to-back memory instructions and a memory instruction at the boot address.
- R8: `cycle_cnt` increases by one every cycle. `retire_cnt` increases once for each valid instruction that leaves write-back, unknown ops and no-ops included. Once drained, `retire_cnt` = `cycle_cnt` − 4 − (number of memory instructions).
- R9: The first instruction's register write shows on `wb_en` when `cycle_cnt` equals 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | AW | Shared port address (fetch or data) |
| mem_wen | output | 1 | Shared port write enable (store) |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Read data, same cycle as address |
| fetch_stall | output | 1 | Fetch lost the port this cycle |
| stage_vld | output | 4 | Valid bits: [0] IF/ID, [1] ID/EX, [2] EX/MEM, [3] MEM/WB |
| wb_en | output | 1 | Register write this cycle |
| wb_rd | output | 3 | Register being written |
| wb_data | output | 16 | Value being written |
| cycle_cnt | output | CW | Cycles since reset |
| retire_cnt | output | CW | Instructions retired since reset |

## Verification
The bench sweeps generated programs with no memory operations, only loads, only stores, alternating loads and stores, mixed patterns with unknown opcodes and register-0 targets, and a load at the boot address. A design that let a back-to-back memory op share one stall, or that fetched during a stall, would show a skipped or duplicated fetch address and a retire count off by the missing stalls. A design that dropped the bubble would let the held instruction execute twice, giving an extra or wrong write-back. A missing write-back bypass would show stale operands exactly at distance three.

// File: rtl/sp_pipe_pkg.sv
package sp_pipe_pkg;
  localparam int ILEN = 16;
  localparam int NREG = 8;
  localparam int RIDX = $clog2(NREG);
  localparam int IMMW = 6;
  localparam int NSTAGE_REG = 4;

  typedef logic [ILEN-1:0] word_t;
  typedef logic [RIDX-1:0] ridx_t;
  typedef enum logic [2:0] {K_NOP, K_ADD, K_ADDI, K_LOAD, K_STORE} kind_e;

  function automatic kind_e decode_kind(input word_t ir);
    case (ir[15:12])
      4'd1:    return K_ADD;
      4'd2:    return K_ADDI;
      4'd3:    return K_LOAD;
      4'd4:    return K_STORE;
      default: return K_NOP;
    endcase
  endfunction

  function automatic logic kind_writes(input kind_e k);
    return k inside {K_ADD, K_ADDI, K_LOAD};
  endfunction

  function automatic logic kind_mem(input kind_e k);
    return k inside {K_LOAD, K_STORE};
  endfunction

  function automatic word_t second_operand(input kind_e k, input word_t rs2v,
                                           input logic [IMMW-1:0] imm);
    return (k == K_ADD) ? rs2v : {{(ILEN-IMMW){1'b0}}, imm};
  endfunction

  function automatic word_t ex_sum(input word_t a, input word_t b);
    return a + b;
  endfunction
endpackage

// File: rtl/sp_regfile.sv
module sp_regfile import sp_pipe_pkg::*; #(
  parameter int NRD = 3
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  ridx_t             wa,
  input  word_t             wd,
  input  ridx_t [NRD-1:0]   ra,
  output word_t [NRD-1:0]   rdat
);
  word_t regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  // read ports: register 0 is zero; a same-cycle write is passed straight through
  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdat[g] = (ra[g] == '0)              ? '0 :
                     (we && wa == ra[g])        ? wd : regs[ra[g]];
  end
endmodule

// File: rtl/sp_port_arb.sv
module sp_port_arb #(
  parameter int AW = 8
)(
  input  logic          data_req,
  input  logic          data_wr,
  input  logic [AW-1:0] data_addr,
  input  logic [AW-1:0] fetch_addr,
  output logic [AW-1:0] port_addr,
  output logic          port_wen,
  output logic          fetch_go,
  output logic          fetch_stall
);
  // data access in the memory stage always wins the port
  always_comb begin
    fetch_stall = data_req;
    fetch_go    = !data_req;
    port_addr   = data_req ? data_addr : fetch_addr;
    port_wen    = data_req && data_wr;
  end
endmodule

// File: rtl/sp_perf_cnt.sv
module sp_perf_cnt #(
  parameter int CW = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          retire,
  output logic [CW-1:0] cycles,
  output logic [CW-1:0] retired
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycles  <= '0;
      retired <= '0;
    end else begin
      cycles <= cycles + CW'(1);
      if (retire) retired <= retired + CW'(1);
    end
  end

  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cycles == $past(cycles) + CW'(1)); // R8
endmodule

// File: rtl/sp_pipe_top.sv
module sp_pipe_top import sp_pipe_pkg::*; #(
  parameter int AW        = 8,
  parameter int BOOT_ADDR = 128,
  parameter int CW        = 16
)(
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [AW-1:0]         mem_addr,
  output logic                  mem_wen,
  output logic [ILEN-1:0]       mem_wdata,
  input  logic [ILEN-1:0]       mem_rdata,
  output logic                  fetch_stall,
  output logic [NSTAGE_REG-1:0] stage_vld,
  output logic                  wb_en,
  output logic [RIDX-1:0]       wb_rd,
  output logic [ILEN-1:0]       wb_data,
  output logic [CW-1:0]         cycle_cnt,
  output logic [CW-1:0]         retire_cnt
);
  localparam logic [AW-1:0] BOOT_PC = AW'(BOOT_ADDR);

  logic [AW-1:0] pc;
  logic  ifid_vld;  word_t ifid_ir;
  logic  idex_vld;  kind_e idex_kind;  ridx_t idex_rd;  word_t idex_a, idex_b, idex_sd;
  logic  exmem_vld; kind_e exmem_kind; ridx_t exmem_rd; word_t exmem_res, exmem_sd;
  logic  memwb_vld; kind_e memwb_kind; ridx_t memwb_rd; word_t memwb_val;

  // named internal events
  logic          fetch_go;
  logic          data_req;
  kind_e         id_kind;
  ridx_t [2:0]   id_ra;
  word_t [2:0]   id_rv;

  assign id_kind = decode_kind(ifid_ir);
  assign id_ra   = {ifid_ir[11:9], ifid_ir[5:3], ifid_ir[8:6]}; // [2] store src, [1] rs2, [0] rs1
  assign data_req = exmem_vld && kind_mem(exmem_kind);

  assign wb_en   = memwb_vld && kind_writes(memwb_kind) && memwb_rd != '0;
  assign wb_rd   = memwb_rd;
  assign wb_data = memwb_val;
  assign mem_wdata = exmem_sd;
  assign stage_vld = {memwb_vld, exmem_vld, idex_vld, ifid_vld};

  sp_regfile #(.NRD(3)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(wb_en), .wa(memwb_rd), .wd(memwb_val),
    .ra(id_ra), .rdat(id_rv)
  );

  sp_port_arb #(.AW(AW)) u_arb (
    .data_req(data_req), .data_wr(exmem_kind == K_STORE),
    .data_addr(exmem_res[AW-1:0]), .fetch_addr(pc),
    .port_addr(mem_addr), .port_wen(mem_wen),
    .fetch_go(fetch_go), .fetch_stall(fetch_stall)
  );

  sp_perf_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .retire(memwb_vld),
    .cycles(cycle_cnt), .retired(retire_cnt)
  );

  // fetch: holds on a stall
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= BOOT_PC; ifid_vld <= 1'b0; ifid_ir <= '0;
    end else if (fetch_go) begin
      pc <= pc + AW'(1); ifid_vld <= 1'b1; ifid_ir <= mem_rdata;
    end
  end

  // decode -> execute: bubble when fetch is stalled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idex_vld <= 1'b0; idex_kind <= K_NOP; idex_rd <= '0;
      idex_a <= '0; idex_b <= '0; idex_sd <= '0;
    end else begin
      idex_vld  <= ifid_vld && fetch_go;
      idex_kind <= id_kind;
      idex_rd   <= ifid_ir[11:9];
      idex_a    <= id_rv[0];
      idex_b    <= second_operand(id_kind, id_rv[1], ifid_ir[IMMW-1:0]);
      idex_sd   <= id_rv[2];
    end
  end

  // execute -> memory
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exmem_vld <= 1'b0; exmem_kind <= K_NOP; exmem_rd <= '0;
      exmem_res <= '0; exmem_sd <= '0;
    end else begin
      exmem_vld  <= idex_vld;
      exmem_kind <= idex_kind;
      exmem_rd   <= idex_rd;
      exmem_res  <= ex_sum(idex_a, idex_b);
      exmem_sd   <= idex_sd;
    end
  end

  // memory -> write-back
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      memwb_vld <= 1'b0; memwb_kind <= K_NOP; memwb_rd <= '0; memwb_val <= '0;
    end else begin
      memwb_vld  <= exmem_vld;
      memwb_kind <= exmem_kind;
      memwb_rd   <= exmem_rd;
      memwb_val  <= (exmem_kind == K_LOAD) ? mem_rdata : exmem_res;
    end
  end

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |=> pc == $past(pc)); // R5
  AST_IFID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |=> (ifid_ir == $past(ifid_ir)) && (ifid_vld == $past(ifid_vld))); // R5
  AST_BUBBLE_INJECT: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |=> !idex_vld); // R6
  AST_STALL_FOLLOWS_MEMOP: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_vld && kind_mem(idex_kind)) |=> fetch_stall); // R4
  AST_SINGLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stall && !(idex_vld && kind_mem(idex_kind))) |=> !fetch_stall); // R7
  AST_WEN_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wen |-> (exmem_vld && exmem_kind == K_STORE)); // R4
  AST_RETIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !memwb_vld |=> $stable(retire_cnt)); // R8
endmodule

// File: tb/sim_sp_pipe_top.sv
`timescale 1ns/1ps
module sim_sp_pipe_top;
  localparam int AW = 8;
  localparam int CW = 16;
  localparam int BOOT = 128;
  localparam int PLEN = 31;
  localparam int RUN = 90;
  localparam int NPROG = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic mem_wen;
  logic [15:0] mem_wdata, mem_rdata;
  logic fetch_stall;
  logic [3:0] stage_vld;
  logic wb_en;
  logic [2:0] wb_rd;
  logic [15:0] wb_data;
  logic [CW-1:0] cycle_cnt, retire_cnt;

  logic [15:0] mem [256];
  logic [15:0] gmem [64];
  logic [2:0]  exp_rd [64];
  logic [15:0] exp_val [64];
  logic [7:0]  mop_addr [64];
  logic        mop_st [64];
  int n_exp, n_mop, nchk, nfail;

  assign mem_rdata = mem[mem_addr];
  always #2.5 clk = ~clk;
  always @(posedge clk) if (rst_n && mem_wen) mem[mem_addr] <= mem_wdata;

  sp_pipe_top #(.AW(AW), .BOOT_ADDR(BOOT), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wen(mem_wen),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .fetch_stall(fetch_stall),
    .stage_vld(stage_vld), .wb_en(wb_en), .wb_rd(wb_rd), .wb_data(wb_data),
    .cycle_cnt(cycle_cnt), .retire_cnt(retire_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // program generator and sequential reference model
  task automatic build(input int p);
    logic [15:0] g [8];
    for (int a = 0; a < 256; a++) mem[a] = 16'h0;
    for (int a = 0; a < 64; a++) begin
      mem[a] = 16'(16'h1000 + a * 37 + p);
      gmem[a] = mem[a];
    end
    for (int r = 0; r < 8; r++) g[r] = 16'h0;
    n_exp = 0; n_mop = 0;
    for (int j = 0; j < PLEN; j++) begin
      int kind, d, s1, s2, imm;
      logic [15:0] ins, v;
      if (j < 7) begin
        kind = 1; d = j + 1; s1 = 0; s2 = 0; imm = (p * 5 + j * 9 + 1) % 64;
        if (j == 0 && p >= 8) begin kind = 2; imm = p; end
      end else begin
        d = (j % 7) + 1; s1 = ((j + 3) % 7) + 1; s2 = ((j + 4) % 7) + 1;
        case (p)
          0: kind = j % 2;
          1: kind = 2;
          2: kind = 3;
          3: kind = 2 + (j % 2);
          default: kind = (j * (p + 3) + p) % 5;
        endcase
        imm = (kind >= 2) ? (j * 11 + p * 7) % 64 : (j * 13 + p) % 64;
        if (kind == 1 && j % 5 == 0) d = 0;
      end
      case (kind)
        0: begin
          ins = {4'd1, 3'(d), 3'(s1), 3'(s2), 3'd0};
          v = g[s1] + g[s2];
          if (d != 0) begin g[d] = v; exp_rd[n_exp] = 3'(d); exp_val[n_exp] = v; n_exp++; end
        end
        1: begin
          ins = {4'd2, 3'(d), 3'(s1), 6'(imm)};
          v = g[s1] + 16'(imm);
          if (d != 0) begin g[d] = v; exp_rd[n_exp] = 3'(d); exp_val[n_exp] = v; n_exp++; end
        end
        2: begin
          ins = {4'd3, 3'(d), 3'd0, 6'(imm)};
          v = gmem[imm];
          g[d] = v; exp_rd[n_exp] = 3'(d); exp_val[n_exp] = v; n_exp++;
          mop_addr[n_mop] = 8'(imm); mop_st[n_mop] = 1'b0; n_mop++;
        end
        3: begin
          ins = {4'd4, 3'(s2), 3'd0, 6'(imm)};
          gmem[imm] = g[s2];
          mop_addr[n_mop] = 8'(imm); mop_st[n_mop] = 1'b1; n_mop++;
        end
        default: ins = {4'hF, 3'(d), 3'(s1), 6'd0};
      endcase
      mem[BOOT + j] = ins;
    end
  endtask

  task automatic run(input int p);
    int stalls, widx, first_wb;
    bit prev_stall;
    rst_n = 1'b0;
    build(p);
    repeat (2) @(negedge clk);
    chk(stage_vld == 4'd0 && mem_wen == 1'b0, "R1 reset state", int'(stage_vld), 0);
    rst_n = 1'b1;
    #1;
    chk(cycle_cnt == 0 && retire_cnt == 0 && fetch_stall == 1'b0, "R1 after release",
        int'(cycle_cnt) + int'(retire_cnt), 0);
    stalls = 0; widx = 0; first_wb = -1; prev_stall = 1'b0;
    for (int k = 0; k <= RUN; k++) begin
      if (k > 0) @(negedge clk);
      if (prev_stall) chk(stage_vld[1] == 1'b0, "R6 bubble", int'(stage_vld[1]), 0);
      if (fetch_stall) begin
        if (stalls < n_mop)
          chk(mem_addr == mop_addr[stalls] && mem_wen == mop_st[stalls], "R4 data access",
              int'(mem_addr), int'(mop_addr[stalls]));
        else
          chk(1'b0, "R7 extra stall", stalls + 1, n_mop);
        stalls++;
      end else begin
        chk(mem_addr == AW'(BOOT + k - stalls) && mem_wen == 1'b0, "R5 fetch address",
            int'(mem_addr), (BOOT + k - stalls) % 256);
      end
      if (wb_en) begin
        if (first_wb < 0) first_wb = k;
        if (widx < n_exp)
          chk(wb_rd == exp_rd[widx] && wb_data == exp_val[widx], "R3 writeback",
              int'(wb_data), int'(exp_val[widx]));
        else
          chk(1'b0, "R3 extra write", widx + 1, n_exp);
        widx++;
      end
      prev_stall = fetch_stall;
    end
    chk(first_wb == 4, "R9 first writeback cycle", first_wb, 4);
    chk(widx == n_exp, "R3 write count", widx, n_exp);
    chk(stalls == n_mop, "R7 stall count", stalls, n_mop);
    chk(cycle_cnt == CW'(RUN), "R8 cycle count", int'(cycle_cnt), RUN);
    chk(retire_cnt == CW'(RUN - 4 - n_mop), "R8 retire count", int'(retire_cnt), RUN - 4 - n_mop);
    for (int a = 0; a < 64; a++)
      chk(mem[a] == gmem[a], "R2 stored data", int'(mem[a]), int'(gmem[a]));
  endtask

  initial begin
    nchk = 0; nfail = 0;
    for (int p = 0; p < NPROG; p++) run(p);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #1000000;
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule